// File: doc/BRIEF.md
# Processor Bus Cycle Decoder for a Two-Port Peripheral

This block is the host-side front end of a two-port peripheral that sits on an 8-bit processor bus with active-low strobes. On every rising edge of the system clock it samples chip enable, I/O request, read and the machine-cycle-one strobe together with the two select lines and the incoming data byte. From that sample it classifies the bus activity as a port read, a data-register write, a control-register write, an interrupt acknowledge, an opcode fetch (which it ignores) or a peripheral reset request.

For reads it drives the selected port's byte onto the data bus with a tri-state enable. For writes it emits a single-clock strobe for the targeted register of port A or port B, together with the captured byte. During an interrupt acknowledge it supplies the vector of the highest-priority pending port, with port A ranked above port B. A daisy-chain enable pair carries priority to other devices on the bus. When machine-cycle-one is asserted alone, the block raises a synchronous reset for the port logic behind it.

Top module: `cpu_bus_front`

## Requirements
- R1: A read cycle (chip enable, I/O request and read low, machine-cycle-one high) sampled at a clock edge sets `db_oe` after that edge. `db_out` then carries `rd_a` when `sel_b` is 0 and `rd_b` when `sel_b` is 1.
- R2: A write cycle (chip enable and I/O request low, read and machine-cycle-one high) pulses one bit after the first edge that samples it. The bit is in `wr_ctl_stb` when `sel_ctl` is 1, otherwise in `wr_data_stb`. Index 0 is port A and index 1 is port B. `wr_byte` shows the sampled `db_in`.
- R3: Each write cycle gives exactly one strobe clock, however many clocks it is held. A later write cycle gives a fresh strobe.
- R4: During an interrupt acknowledge (machine-cycle-one and I/O request low), with `ien_in` high, the bus is driven with `vec_a` if port A is pending, or else with `vec_b` if only port B is pending. With `ien_in` low or nothing pending, the bus is not driven.
- R5: `ien_out` is high only when `ien_in` is high and neither port has a latched pending request.
- R6: Requests from `irq_req` are latched only while machine-cycle-one was sampled high. A change during a machine-cycle-one period has no effect on the grant or on `ien_out` until one clock after machine-cycle-one returns high.
- R7: An opcode fetch (machine-cycle-one and read low) drives no bus, no strobe and no reset.
- R8: Machine-cycle-one low with read and I/O request high raises `periph_rst` from the first edge that samples it until the first edge after it ends. It clears the latched requests, so `ien_out` follows `ien_in` during it and for one clock after it ends.
- R9: With chip enable high outside an acknowledge, the bus is not driven and no strobe occurs.
- R10: An acknowledge with chip enable low and read high produces no write strobe.
- R11: While `rst_n` is low, `db_oe`, all strobes and `periph_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase system clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ce_n | input | 1 | Chip enable, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| sel_b | input | 1 | Port select: 0 port A, 1 port B |
| sel_ctl | input | 1 | Register select: 0 data, 1 control |
| db_in | input | 8 | Data bus as seen from the pins |
| db_out | output | 8 | Data driven toward the bus |
| db_oe | output | 1 | Tri-state buffer enable for `db_out` |
| rd_a | input | 8 | Read data of port A |
| rd_b | input | 8 | Read data of port B |
| vec_a | input | 8 | Interrupt vector of port A |
| vec_b | input | 8 | Interrupt vector of port B |
| irq_req | input | 2 | Interrupt requests, bit 0 port A, bit 1 port B |
| ien_in | input | 1 | Daisy-chain enable from higher-priority devices |
| ien_out | output | 1 | Daisy-chain enable to lower-priority devices |
| wr_data_stb | output | 2 | One-clock data-register write strobes per port |
| wr_ctl_stb | output | 2 | One-clock control-register write strobes per port |
| wr_byte | output | 8 | Byte captured for the write |
| periph_rst | output | 1 | Synchronous reset for the port logic |

## Verification
An interrupt acknowledge and a write can land in the same sampled cycle. This happens when the processor holds chip enable low and read high while it drops machine-cycle-one and I/O request together. The bench provokes this overlap on purpose and judges it by requiring the pending port's vector on the bus with every write strobe silent. A second overlap is a request change during the acknowledge itself. The bench raises a new request one clock into the acknowledge and requires the grant and the chain output to stay as latched until machine-cycle-one has been high for a clock.

// File: rtl/cpu_bus_front.sv
module cpu_bus_front #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          iorq_n,
  input  logic          rd_n,
  input  logic          m1_n,
  input  logic          sel_b,
  input  logic          sel_ctl,
  input  logic [DW-1:0] db_in,
  output logic [DW-1:0] db_out,
  output logic          db_oe,
  input  logic [DW-1:0] rd_a,
  input  logic [DW-1:0] rd_b,
  input  logic [DW-1:0] vec_a,
  input  logic [DW-1:0] vec_b,
  input  logic [1:0]    irq_req,
  input  logic          ien_in,
  output logic          ien_out,
  output logic [1:0]    wr_data_stb,
  output logic [1:0]    wr_ctl_stb,
  output logic [DW-1:0] wr_byte,
  output logic          periph_rst
);

  logic          s_ce, s_iorq, s_rd, s_m1, s_selb, s_ctl;
  logic [DW-1:0] s_d;
  logic          wr_seen;
  logic [1:0]    irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce   <= 1'b1;
      s_iorq <= 1'b1;
      s_rd   <= 1'b1;
      s_m1   <= 1'b1;
      s_selb <= 1'b0;
      s_ctl  <= 1'b0;
      s_d    <= '0;
    end else begin
      s_ce   <= ce_n;
      s_iorq <= iorq_n;
      s_rd   <= rd_n;
      s_m1   <= m1_n;
      s_selb <= sel_b;
      s_ctl  <= sel_ctl;
      s_d    <= db_in;
    end
  end

  logic rd_cyc, wr_cyc, ack_cyc, rst_cyc, wr_go;
  assign rd_cyc  = !s_ce && !s_iorq && !s_rd && s_m1;
  assign wr_cyc  = !s_ce && !s_iorq && s_rd && s_m1;
  assign ack_cyc = !s_m1 && !s_iorq;
  assign rst_cyc = !s_m1 && s_rd && s_iorq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen <= 1'b0;
    else        wr_seen <= wr_cyc;
  end

  assign wr_go = wr_cyc && !wr_seen;

  logic [1:0] port_sel;
  assign port_sel    = s_selb ? 2'b10 : 2'b01;
  assign wr_data_stb = (wr_go && !s_ctl) ? port_sel : 2'b00;
  assign wr_ctl_stb  = (wr_go &&  s_ctl) ? port_sel : 2'b00;
  assign wr_byte     = s_d;
  assign periph_rst  = rst_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_q <= 2'b00;
    else if (rst_cyc) irq_q <= 2'b00;
    else if (s_m1)    irq_q <= irq_req;
  end

  logic [1:0] pend;
  logic       gnt_a, gnt_b;
  assign pend    = rst_cyc ? 2'b00 : irq_q;
  assign gnt_a   = ien_in && pend[0];
  assign gnt_b   = ien_in && pend[1] && !pend[0];
  assign ien_out = ien_in && (pend == 2'b00);

  always_comb begin
    db_oe  = 1'b0;
    db_out = '0;
    if (ack_cyc) begin
      db_oe  = gnt_a || gnt_b;
      db_out = gnt_a ? vec_a : (gnt_b ? vec_b : '0);
    end else if (rd_cyc) begin
      db_oe  = 1'b1;
      db_out = s_selb ? rd_b : rd_a;
    end
  end

endmodule

// File: rtl/cpu_bus_front_chk.sv
module cpu_bus_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       iorq_n,
  input logic       rd_n,
  input logic       m1_n,
  input logic       db_oe,
  input logic       ien_in,
  input logic       ien_out,
  input logic [1:0] wr_data_stb,
  input logic [1:0] wr_ctl_stb,
  input logic       periph_rst
);

  logic [3:0] stb;
  assign stb = {wr_ctl_stb, wr_data_stb};

  p_onehot_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb != 4'b0) |=> (stb == 4'b0));

  p_oe_needs_iorq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    db_oe |-> ($past(!iorq_n) && !periph_rst));

  p_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ien_out |-> ien_in);

  p_fetch_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!m1_n && !rd_n) |-> (!db_oe && !periph_rst && stb == 4'b0));

  p_ack_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!m1_n) |-> (stb == 4'b0));

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> (!db_oe && stb == 4'b0));

endmodule

bind cpu_bus_front cpu_bus_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .m1_n(m1_n),
  .db_oe(db_oe), .ien_in(ien_in), .ien_out(ien_out),
  .wr_data_stb(wr_data_stb), .wr_ctl_stb(wr_ctl_stb), .periph_rst(periph_rst)
);

// File: tb/sim_cpu_bus_front.sv
`timescale 1ns/1ps
module sim_cpu_bus_front;
  logic clk = 0, rst_n = 0;
  logic ce_n = 1, iorq_n = 1, rd_n = 1, m1_n = 1, sel_b = 0, sel_ctl = 0;
  logic [7:0] db_in = 0, rd_a = 8'h5A, rd_b = 8'hC3, vec_a = 8'h40, vec_b = 8'h62;
  logic [1:0] irq_req = 0;
  logic ien_in = 1;
  logic [7:0] db_out, wr_byte;
  logic db_oe, ien_out, periph_rst;
  logic [1:0] wr_data_stb, wr_ctl_stb;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  cpu_bus_front u0 (.*);

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic drive(input logic ce, iorq, rd, m1, sb, sc, input logic [7:0] d);
    @(negedge clk);
    ce_n = ce; iorq_n = iorq; rd_n = rd; m1_n = m1; sel_b = sb; sel_ctl = sc; db_in = d;
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic idle(input int n);
    drive(1, 1, 1, 1, 0, 0, 8'h00);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic t_reset();
    #1;
    chk(db_oe, 0, "R11 oe in reset");
    chk({wr_data_stb, wr_ctl_stb}, 0, "R11 strobes in reset");
    chk(periph_rst, 0, "R11 periph_rst in reset");
  endtask

  task automatic t_read();
    drive(0, 0, 0, 1, 0, 0, 8'h00); tick();
    chk(db_oe, 1, "R1 oe port A");
    chk(db_out, 8'h5A, "R1 data port A");
    drive(0, 0, 0, 1, 1, 0, 8'h00); tick();
    chk(db_out, 8'hC3, "R1 data port B");
    idle(1);
    chk(db_oe, 0, "R1 oe released");
  endtask

  task automatic t_write();
    drive(0, 0, 1, 1, 1, 0, 8'h3C); tick();
    chk(wr_data_stb, 2'b10, "R2 data strobe port B");
    chk(wr_ctl_stb, 2'b00, "R2 no ctl strobe");
    chk(wr_byte, 8'h3C, "R2 write byte");
    tick();
    chk({wr_data_stb, wr_ctl_stb}, 0, "R3 single strobe while held");
    tick();
    chk({wr_data_stb, wr_ctl_stb}, 0, "R3 still single");
    idle(1);
    drive(0, 0, 1, 1, 0, 1, 8'h81); tick();
    chk(wr_ctl_stb, 2'b01, "R2 ctl strobe port A");
    chk(wr_byte, 8'h81, "R2 ctl byte");
    idle(1);
    drive(0, 0, 1, 1, 0, 1, 8'h17); tick();
    chk(wr_ctl_stb, 2'b01, "R3 fresh strobe next cycle");
    idle(1);
  endtask

  task automatic t_ack();
    irq_req = 2'b11; ien_in = 1; idle(2);
    drive(0, 0, 1, 0, 0, 0, 8'h99); tick();
    chk(db_oe, 1, "R4 ack drives");
    chk(db_out, 8'h40, "R4 port A wins");
    chk({wr_data_stb, wr_ctl_stb}, 0, "R10 no write during ack");
    chk(ien_out, 0, "R5 chain blocked");
    irq_req = 2'b10; idle(2);
    drive(1, 0, 1, 0, 0, 0, 8'h00); tick();
    chk(db_out, 8'h62, "R4 port B vector");
    ien_in = 0; #1;
    chk(db_oe, 0, "R4 no drive without ien_in");
    chk(ien_out, 0, "R5 ien_in low");
    ien_in = 1; irq_req = 0; idle(2);
    chk(ien_out, 1, "R5 chain passes when idle");
  endtask

  task automatic t_freeze();
    irq_req = 0; idle(2);
    drive(1, 0, 1, 0, 0, 0, 8'h00); tick();
    chk(db_oe, 0, "R4 nothing pending");
    @(negedge clk); irq_req = 2'b01; tick();
    chk(db_oe, 0, "R6 new request ignored in ack");
    chk(ien_out, 1, "R6 chain held in ack");
    idle(1);
    chk(ien_out, 1, "R6 not yet latched");
    tick();
    chk(ien_out, 0, "R6 latched after m1 high");
  endtask

  task automatic t_fetch();
    drive(0, 1, 0, 0, 0, 0, 8'h00); tick();
    chk(db_oe, 0, "R7 fetch no drive");
    chk(periph_rst, 0, "R7 fetch no reset");
    chk({wr_data_stb, wr_ctl_stb}, 0, "R7 fetch no strobe");
    idle(1);
  endtask

  task automatic t_mreset();
    irq_req = 2'b01; idle(2);
    chk(ien_out, 0, "R8 pending before");
    drive(1, 1, 1, 0, 0, 0, 8'h00); tick();
    chk(periph_rst, 1, "R8 reset raised");
    chk(ien_out, 1, "R8 pending cleared");
    tick();
    chk(periph_rst, 1, "R8 reset held");
    idle(1);
    chk(periph_rst, 0, "R8 reset released");
    chk(ien_out, 1, "R8 still cleared");
    tick();
    chk(ien_out, 0, "R8 relatched");
    irq_req = 0; idle(2);
  endtask

  task automatic t_idle();
    drive(1, 0, 0, 1, 0, 0, 8'h00); tick();
    chk(db_oe, 0, "R9 ce high read");
    drive(1, 0, 1, 1, 0, 0, 8'hAA); tick();
    chk({wr_data_stb, wr_ctl_stb}, 0, "R9 ce high write");
    idle(1);
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    idle(2);
    t_read();
    t_write();
    t_ack();
    t_freeze();
    t_fetch();
    t_mreset();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule